// File: doc/BRIEF.md
# Page-Mode Asynchronous Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR flash and serves single-word reads. A requester offers a word address on a valid/ready port. The controller drives chip enable, output enable, write enable and the address pins, waits a fixed number of clock cycles, samples the flash data bus and returns the word with a one-cycle valid strobe. Only one read is in flight at a time.

The flash delivers words of the page it already holds open much faster than words from a new page. The controller remembers which eight-word page is open and whether chip enable has stayed low since that page was opened. A read that hits that page waits only the short in-page time. Any other read waits the full initial access time. After a programmable number of idle cycles the controller releases chip enable and forgets the page, so the next read pays the full time again.

All timing values are parameters counted in clock cycles: `T_ACC` (initial access), `T_PACC` (in-page access), `T_OE` (output enable to data) and `IDLE_TO` (idle cycles before release; 0 keeps the device selected for good). No command is issued before the first read, because the flash is in its read-array state after reset.

Top module: `pfr_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no request, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0. A read needs no command beforehand. Whenever `flash_ce_n` is 1, `flash_oe_n` is also 1.
- R2: `flash_we_n` is always 1. `flash_ce_n` is 0 for the whole time a read is in flight.
- R3: The page of an address is `addr[ADDR_W-1:3]` and the word within the page is `addr[2:0]`. Two addresses hit the same page only if all page bits are equal.
- R4: Some reads wait the full time: the first read after reset, a read while chip enable is released, and a read to a page other than the open one. For such a read, `rsp_valid` rises exactly `T_ACC` clock edges after the accepting edge.
- R5: A read to the open page, made while chip enable has stayed low since that page was opened, raises `rsp_valid` exactly `T_PACC` edges after the accepting edge.
- R6: After `IDLE_TO` consecutive edges in the open state with no accepted request, `flash_ce_n` and `flash_oe_n` go to 1 and the page is forgotten. The next read then waits `T_ACC`, even within the same page. A request accepted on the `IDLE_TO`-th edge still counts as a hit.
- R7: On a full-time read, `flash_oe_n` falls `T_OE` edges before the sampling edge, which is `T_ACC - T_OE` edges after acceptance. On a page hit it is already low. It is low on the sampling edge of every read.
- R8: `req_ready` is 0 from the accepting edge until `rsp_valid` is shown. It is 1 in the cycle that shows `rsp_valid`. `rsp_valid` never lasts more than one cycle.
- R9: `flash_addr` holds the accepted address, unchanged, for the whole read. `rsp_data` equals the flash data bus as sampled on the last counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_data | output | DATA_W | Read data |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low (held high) |
| flash_addr | output | ADDR_W | Flash word address |
| flash_dq | input | DATA_W | Flash data bus |

## Verification
The bound checker watches several pin and handshake rules on every cycle:
- write enable stays high, and output enable is never low while chip enable is high;
- chip enable stays low and the address stays unchanged while a read is in flight;
- ready drops after acceptance, and the data strobe lasts one cycle;
- output enable is low at every sampling edge, and no read takes longer than `T_ACC`.

Only the bench scenarios show the things that need an expected value: whether a given read is a hit or a miss, the exact latency, the moment output enable falls, and the data. They use a flash model that returns a poison word whenever the address, page or output-enable age is shorter than the timing allows. The scenarios cover the first read, in-page hits, a page boundary, a far miss, and the idle timeout one edge before and on its expiry.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2
  } pfr_state_e;
endpackage

// File: rtl/pfr_page_tracker.sv
module pfr_page_tracker #(
  parameter int ADDR_W = 22,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WORD_W;

  logic [TAG_W-1:0] tag_q;
  logic             vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clear)     vld_d = 1'b0;
    else if (load) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= '0;
    else if (load) tag_q <= addr_in[ADDR_W-1:WORD_W];
  end

  assign hit = vld_q && (tag_q == addr_in[ADDR_W-1:WORD_W]);
endmodule

// File: rtl/pfr_down_timer.sv
module pfr_down_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                  cnt_d = load_val;
    else if (en && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pfr_idle_timer.sv
module pfr_idle_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expire
);
  generate
    if (LIMIT == 0) begin : g_never
      assign expire = 1'b0;
    end else begin : g_count
      localparam int IW = $clog2(LIMIT + 1);
      localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);
      logic [IW-1:0] idle_q, idle_d;

      always_comb begin
        idle_d = idle_q;
        if (clr)     idle_d = '0;
        else if (en) idle_d = (idle_q == LAST) ? '0 : idle_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= '0;
        else        idle_q <= idle_d;
      end

      assign expire = en && !clr && (idle_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 8,
  parameter int T_ACC      = 7,
  parameter int T_PACC     = 3,
  parameter int T_OE       = 3,
  parameter int IDLE_TO    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_dq
);
  import pfr_pkg::*;

  localparam int WORD_W = $clog2(PAGE_WORDS);
  localparam int CNT_W  = $clog2(T_ACC + 1);
  localparam logic [CNT_W-1:0] FULL_LD = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] HIT_LD  = CNT_W'(T_PACC - 1);
  localparam logic [CNT_W-1:0] OE_AT   = CNT_W'(T_OE);
  localparam logic OE_EARLY = (T_ACC <= T_OE);

  pfr_state_e        state_q, state_d;
  logic              ce_n_q, ce_n_d, oe_n_q, oe_n_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, capture;
  logic              page_hit, page_clr;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val, tmr_cnt;
  logic              idle_en, idle_clr, idle_expire;

  assign req_ready = (state_q != ST_WAIT);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_WAIT) && tmr_zero;

  pfr_page_tracker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(accept), .clear(page_clr),
    .addr_in(req_addr), .hit(page_hit)
  );

  pfr_down_timer #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(state_q == ST_WAIT), .cnt(tmr_cnt), .zero(tmr_zero)
  );

  assign idle_en  = (state_q == ST_OPEN) && !accept;
  assign idle_clr = (state_q != ST_OPEN) || accept;

  pfr_idle_timer #(.LIMIT(IDLE_TO)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .en(idle_en),
    .expire(idle_expire)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ce_n_d   = ce_n_q;
    oe_n_d   = oe_n_q;
    rsp_v_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = FULL_LD;
    page_clr = 1'b0;
    case (state_q)
      ST_IDLE, ST_OPEN: begin
        if (accept) begin
          state_d  = ST_WAIT;
          ce_n_d   = 1'b0;
          tmr_load = 1'b1;
          if (state_q == ST_OPEN && page_hit) begin
            tmr_val = HIT_LD;
            oe_n_d  = 1'b0;
          end else begin
            tmr_val = FULL_LD;
            oe_n_d  = !OE_EARLY;
          end
        end else if (idle_expire) begin
          state_d  = ST_IDLE;
          ce_n_d   = 1'b1;
          oe_n_d   = 1'b1;
          page_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          state_d = ST_OPEN;
          rsp_v_d = 1'b1;
        end else if (tmr_cnt == OE_AT) begin
          oe_n_d = 1'b0;
        end
      end
      default: begin
        state_d  = ST_IDLE;
        ce_n_d   = 1'b1;
        oe_n_d   = 1'b1;
        page_clr = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= flash_dq;
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_data   = data_q;
  assign flash_ce_n = ce_n_q;
  assign flash_oe_n = oe_n_q;
  assign flash_we_n = 1'b1;
  assign flash_addr = addr_q;
endmodule

// File: rtl/pfr_checks.sv
module pfr_checks #(
  parameter int ADDR_W = 22,
  parameter int T_ACC  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              flash_we_n,
  input logic [ADDR_W-1:0] flash_addr
);
  int unsigned lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat_q <= 0;
    else if (req_valid && req_ready) lat_q <= 1;
    else if (!req_ready)             lat_q <= lat_q + 1;
  end

  p_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_we_n);
  p_oe_needs_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ce_n |-> flash_oe_n);
  p_ce_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !flash_ce_n);
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(flash_addr));
  p_oe_at_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && lat_q != 0) |=> (rsp_valid |-> $past(!flash_oe_n)));
  p_lat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (lat_q <= T_ACC));
endmodule

bind pfr_ctrl pfr_checks #(.ADDR_W(ADDR_W), .T_ACC(T_ACC)) u_pfr_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
  .flash_we_n(flash_we_n), .flash_addr(flash_addr)
);

// File: tb/test_pfr_ctrl.sv
`timescale 1ns/1ps
module test_pfr_ctrl;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int TA = 7;
  localparam int TP = 3;
  localparam int TO = 3;
  localparam int IT = 12;

  logic          clk, rst_n, req_valid, req_ready, rsp_valid;
  logic [AW-1:0] req_addr, flash_addr;
  logic [DW-1:0] rsp_data, flash_dq;
  logic          flash_ce_n, flash_oe_n, flash_we_n;

  int checks = 0;
  int fails  = 0;

  pfr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(8), .T_ACC(TA),
             .T_PACC(TP), .T_OE(TO), .IDLE_TO(IT)) i_pfr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_addr(flash_addr), .flash_dq(flash_dq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural flash: poison word unless all ages satisfy the timing
  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[15:0] ^ {4'hA, a[21:10]};
  endfunction

  int pg_age, wd_age, oe_age;
  logic [AW-1:0] prev_addr;
  logic prev_ce, prev_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      pg_age = 0; wd_age = 0; oe_age = 0;
      prev_addr = '0; prev_ce = 1'b1; prev_oe = 1'b1;
    end else begin
      if (flash_ce_n) begin
        pg_age = 0; wd_age = 0;
      end else begin
        if (prev_ce || flash_addr[AW-1:3] != prev_addr[AW-1:3]) pg_age = 1;
        else if (pg_age < 1000) pg_age++;
        if (prev_ce || flash_addr != prev_addr) wd_age = 1;
        else if (wd_age < 1000) wd_age++;
      end
      if (flash_oe_n) oe_age = 0;
      else if (prev_oe) oe_age = 1;
      else if (oe_age < 1000) oe_age++;
      prev_addr = flash_addr; prev_ce = flash_ce_n; prev_oe = flash_oe_n;
    end
  end

  assign flash_dq = (!flash_ce_n && !flash_oe_n && pg_age >= TA - 1 &&
                     wd_age >= TP - 1 && oe_age >= TO - 1 && oe_age > 0)
                    ? word_of(flash_addr) : 16'hDEAD;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one read: checks latency, OE fall point, busy ready/CE and data
  task automatic do_read(input logic [AW-1:0] a, input int exp_lat,
                         input int exp_oe, input string rq);
    int lat, oe_first;
    bit busy_ok;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0; busy_ok = 1'b1; oe_first = -1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready || flash_ce_n || flash_we_n != 1'b1 || flash_addr != a) busy_ok = 1'b0;
      if (oe_first < 0 && !flash_oe_n) oe_first = lat;
      @(posedge clk); #1;
      lat++;
    end
    chk(lat == exp_lat, rq, lat, exp_lat);
    chk(oe_first == exp_oe, "R7 output enable fall point", oe_first, exp_oe);
    chk(busy_ok, "R2 R8 R9 pins during read", int'(busy_ok), 1);
    chk(rsp_data == word_of(a), "R9 read data", int'(rsp_data), int'(word_of(a)));
    chk(req_ready == 1'b1, "R8 ready with response", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(flash_ce_n == 1'b1, "R1 ce after reset", flash_ce_n, 1);
    chk(flash_oe_n == 1'b1, "R1 oe after reset", flash_oe_n, 1);
    chk(flash_we_n == 1'b1, "R1 we after reset", flash_we_n, 1);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_first_and_hits();
    do_read(22'h012345, TA, TA - TO, "R4 first read full latency");
    do_read(22'h012340, TP, 0, "R5 hit word 0");
    do_read(22'h012347, TP, 0, "R5 hit word 7");
    do_read(22'h012342, TP, 0, "R5 hit word 2");
    @(negedge clk);
    chk(flash_ce_n == 1'b0, "R5 ce held between hits", flash_ce_n, 0);
  endtask

  task automatic t_boundary();
    do_read(22'h00004F, TA, TA - TO, "R3 new page full latency");
    do_read(22'h000048, TP, 0, "R3 same page hit");
    do_read(22'h000040, TA, TA - TO, "R3 bit 3 differs miss");
    do_read(22'h200040, TA, TA - TO, "R3 top bit differs miss");
    do_read(22'h200046, TP, 0, "R3 back in page hit");
  endtask

  task automatic t_idle_edge();
    repeat (IT - 1) @(posedge clk);
    do_read(22'h200041, TP, 0, "R6 request on last idle edge is hit");
  endtask

  task automatic t_idle_close();
    repeat (IT) @(posedge clk);
    #1;
    chk(flash_ce_n == 1'b1, "R6 ce released by idle timeout", flash_ce_n, 1);
    chk(flash_oe_n == 1'b1, "R6 oe released by idle timeout", flash_oe_n, 1);
    do_read(22'h200043, TA, TA - TO, "R6 same page after release full latency");
    do_read(22'h200044, TP, 0, "R5 hit after reopen");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flash_ce_n == 1'b1 && rsp_valid == 1'b0, "R1 pins during reset", flash_ce_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_and_hits();
    t_boundary();
    t_idle_edge();
    t_idle_close();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule